// File: doc/BRIEF.md
# Processor status flag register

This block holds the 8-bit status word of a processor core and applies every change to it. It has three sources of updates. The first is the arithmetic path. The ALU delivers a result, the operand size, and its carries at fixed bit positions. From these the block derives the negative, zero, overflow, carry and half-carry flags for the selected size. The second is software. A command can overwrite the whole word with an immediate byte, or combine the word with that byte by AND, OR or XOR. The third is exception entry, which forces the interrupt mask bit high.

The current word is always readable on `ccr`. The mask bit is also driven out alone on `irq_mask` for the interrupt controller. That controller masks every maskable source while the bit is high and lets the non-maskable interrupt through in all cases. Updates take effect on the rising clock edge. Reset is synchronous and active high. At reset the mask bit is set, and every other bit, which has no defined reset value, is loaded with 0.

Bit layout: 7 mask I, 6 user bit UI, 5 half-carry H, 4 user bit U, 3 negative N, 2 zero Z, 1 overflow V, 0 carry C.

Top module: `ccr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the register loads 8'h80, so `irq_mask` is 1 after reset.
- R2: `irq_mask` equals bit 7 of `ccr` at all times. It is high (maskable interrupts masked) exactly when I is 1.
- R3: When `exc_enter` is high, bit 7 becomes 1 at the next edge. This holds even if the same cycle carries a load or logic command that would clear it; the other bits still take that command's result.
- R4: `cmd`=1 (arithmetic) sets N to the result MSB for the size, and Z to 1 exactly when the sized result is zero. Size codes: 0 byte (bits 7:0), 1 word (bits 15:0), 2 long (bits 31:0).
- R5: On `cmd`=1, C takes `msb_cout[k]` and V takes `msb_cin[k]` XOR `msb_cout[k]`. Here k is 0, 1 or 2 for byte, word or long.
- R6: On `cmd`=1 with `h_en`=1, H takes `half_c[k]`, the carry at bit 3, 11 or 27 for byte, word or long. With `h_en`=0, H keeps its value.
- R7: `cmd`=2 loads `imm` into the whole register.
- R8: `cmd`=3, 4 and 5 replace the register with its AND, OR or XOR with `imm`, respectively.
- R9: `cmd` 0, 6 and 7 change nothing. An arithmetic update never changes I, UI or U.
- R10: Size code 3 is treated as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | 0 none, 1 arithmetic, 2 load, 3 AND, 4 OR, 5 XOR, 6/7 none |
| size | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 long |
| result | input | 32 | ALU result, low bits valid for smaller sizes |
| half_c | input | 3 | Carry/borrow at bit 3, 11, 27 (index 0, 1, 2) |
| msb_cin | input | 3 | Carry into sized MSB, byte/word/long |
| msb_cout | input | 3 | Carry/borrow out of sized MSB, byte/word/long |
| h_en | input | 1 | Arithmetic update writes H |
| imm | input | 8 | Immediate byte for load and logic commands |
| exc_enter | input | 1 | Exception sequence begins this cycle |
| ccr | output | 8 | Current register value |
| irq_mask | output | 1 | Interrupt mask to the interrupt controller |

## Verification
The assertions assume that `cmd`, `size`, `imm` and `exc_enter` are stable and known at each rising edge. They also assume that the carry inputs are only meaningful during an arithmetic command. The bench changes all inputs on the falling edge and holds them through the next rising edge. It reads `ccr` on the following falling edge, one register stage after the command. Exception entry is issued both alone and in the same cycle as load and XOR commands, which exercises the priority on bit 7.

// File: rtl/ccr_unit.sv
module ccr_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cmd,
  input  logic [1:0]    size,
  input  logic [DW-1:0] result,
  input  logic [2:0]    half_c,
  input  logic [2:0]    msb_cin,
  input  logic [2:0]    msb_cout,
  input  logic          h_en,
  input  logic [7:0]    imm,
  input  logic          exc_enter,
  output logic [7:0]    ccr,
  output logic          irq_mask
);
  localparam logic [2:0] C_ARITH = 3'd1;
  localparam logic [2:0] C_LOAD  = 3'd2;
  localparam logic [2:0] C_AND   = 3'd3;
  localparam logic [2:0] C_OR    = 3'd4;
  localparam logic [2:0] C_XOR   = 3'd5;
  localparam logic [7:0] RST_VAL = 8'h80;

  logic [7:0] q, nxt;
  logic [1:0] k;
  logic       n_f, z_f;

  assign k = (size == 2'd0) ? 2'd0 : (size == 2'd1) ? 2'd1 : 2'd2;

  always_comb begin
    case (k)
      2'd0:    begin n_f = result[7];  z_f = (result[7:0] == '0);  end
      2'd1:    begin n_f = result[15]; z_f = (result[15:0] == '0); end
      default: begin n_f = result[DW-1]; z_f = (result == '0);     end
    endcase
  end

  always_comb begin
    nxt = q;
    case (cmd)
      C_ARITH: begin
        nxt[3] = n_f;
        nxt[2] = z_f;
        nxt[1] = msb_cin[k] ^ msb_cout[k];
        nxt[0] = msb_cout[k];
        if (h_en) nxt[5] = half_c[k];
      end
      C_LOAD: nxt = imm;
      C_AND:  nxt = q & imm;
      C_OR:   nxt = q | imm;
      C_XOR:  nxt = q ^ imm;
      default: ;
    endcase
    if (exc_enter) nxt[7] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt;
  end

  assign ccr      = q;
  assign irq_mask = q[7];

  a_r1_reset_mask: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ccr == 8'h80));
  a_r3_exc_sets_mask: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> irq_mask);
  a_r9_arith_keeps_ctrl: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ARITH && !exc_enter) |=> ($stable(ccr[7]) && $stable(ccr[6]) && $stable(ccr[4])));
  a_r6_h_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ARITH && !h_en) |=> $stable(ccr[5]));
  a_r4_n_z_exclusive: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ARITH) |=> !(ccr[3] && ccr[2]));
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_LOAD && !exc_enter) |=> (ccr == $past(imm)));
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    ((cmd == 3'd0 || cmd == 3'd6 || cmd == 3'd7) && !exc_enter) |=> $stable(ccr));
endmodule

// File: tb/sim_ccr_unit.sv
module sim_ccr_unit;
  logic        clk = 0;
  logic        rst;
  logic [2:0]  cmd;
  logic [1:0]  size;
  logic [31:0] result;
  logic [2:0]  half_c, msb_cin, msb_cout;
  logic        h_en, exc_enter;
  logic [7:0]  imm, ccr;
  logic        irq_mask;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ccr_unit u0 (.clk(clk), .rst(rst), .cmd(cmd), .size(size), .result(result),
    .half_c(half_c), .msb_cin(msb_cin), .msb_cout(msb_cout), .h_en(h_en),
    .imm(imm), .exc_enter(exc_enter), .ccr(ccr), .irq_mask(irq_mask));

  task automatic chk(input string req, input logic [7:0] exp);
    tests++;
    if (ccr !== exp || irq_mask !== exp[7]) begin
      fails++;
      $display("FAIL %s: ccr=%h mask=%b expected ccr=%h mask=%b", req, ccr, irq_mask, exp, exp[7]);
    end
  endtask

  task automatic op(input logic [2:0] c, input logic [1:0] s, input logic [31:0] r,
                    input logic [2:0] hc, input logic [2:0] ci, input logic [2:0] co,
                    input logic he, input logic [7:0] im, input logic ex,
                    input logic [7:0] exp, input string req);
    cmd = c; size = s; result = r; half_c = hc; msb_cin = ci; msb_cout = co;
    h_en = he; imm = im; exc_enter = ex;
    @(negedge clk);
    chk(req, exp);
    cmd = 0; exc_enter = 0;
  endtask

  task automatic t_reset;
    rst = 1; cmd = 0; size = 0; result = 0; half_c = 0; msb_cin = 0; msb_cout = 0;
    h_en = 0; imm = 0; exc_enter = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R1", 8'h80);
  endtask

  task automatic t_load;
    op(3'd2, 0, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R7 R2");
    op(3'd2, 0, 0, 0, 0, 0, 0, 8'hA5, 0, 8'hA5, "R7");
    op(3'd2, 0, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, "R7");
  endtask

  task automatic t_arith;
    op(3'd1, 2'd0, 32'h0000_0180, 3'b001, 3'b001, 3'b000, 1, 0, 0, 8'h2A, "R4 R5 R6 byte");
    op(3'd1, 2'd1, 32'h0001_0000, 3'b001, 3'b010, 3'b010, 1, 0, 0, 8'h05, "R4 R5 R6 word");
    op(3'd1, 2'd2, 32'h8000_0000, 3'b100, 3'b000, 3'b100, 1, 0, 0, 8'h2B, "R4 R5 R6 long");
    op(3'd1, 2'd3, 32'h0000_0000, 3'b100, 3'b000, 3'b000, 1, 0, 0, 8'h24, "R10");
    op(3'd1, 2'd0, 32'h0000_0001, 3'b000, 3'b000, 3'b000, 0, 0, 0, 8'h20, "R6 hold");
  endtask

  task automatic t_user_bits;
    op(3'd2, 0, 0, 0, 0, 0, 0, 8'h50, 0, 8'h50, "R7");
    op(3'd1, 2'd0, 32'hFFFF_FF00, 3'b111, 3'b000, 3'b000, 0, 0, 0, 8'h54, "R9 arith");
    op(3'd0, 0, 0, 0, 0, 0, 0, 8'hFF, 0, 8'h54, "R9 none");
    op(3'd6, 0, 0, 0, 0, 0, 0, 8'hFF, 0, 8'h54, "R9 code6");
  endtask

  task automatic t_logic;
    op(3'd3, 0, 0, 0, 0, 0, 0, 8'h0F, 0, 8'h04, "R8 and");
    op(3'd4, 0, 0, 0, 0, 0, 0, 8'hC3, 0, 8'hC7, "R8 or R2");
    op(3'd5, 0, 0, 0, 0, 0, 0, 8'hFF, 0, 8'h38, "R8 xor R2");
  endtask

  task automatic t_exc;
    op(3'd0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hB8, "R3 alone");
    op(3'd2, 0, 0, 0, 0, 0, 0, 8'h00, 1, 8'h80, "R3 with load");
    op(3'd5, 0, 0, 0, 0, 0, 0, 8'h83, 1, 8'h83, "R3 with xor");
  endtask

  initial begin
    t_reset;
    t_load;
    t_arith;
    t_user_bits;
    t_logic;
    t_exc;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: done=0 expected done=1");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule